// File: doc/BRIEF.md
# Search-Engine Read Command Sequencer

This block is the device-side read path of a search-engine memory that sits on a shared host bus. The host presents a read instruction for one cycle on a command bus, with command-valid high. The device ID, the target and the address travel on the data bus in that same cycle. The block decides whether the instruction is a read and whether it is addressed to this device, either by exact ID match or by the all-ones code that picks the last device in a cascade. It then runs a fixed-length bus transaction and returns the read word together with a one-cycle acknowledge.

A single read covers six cycles. The instruction occupies cycle 1, data and acknowledge appear in cycle 5, and cycle 6 is the turnaround. A burst read fetches several consecutive words from the data or the mask array. An internal pointer supplies the addresses and advances after every word, and each extra word lengthens the transaction by two cycles. Reads of the external SRAM drive the SRAM address lines for the whole access and leave the data bus to the SRAM. The arrays and registers are modelled as register files loaded with a fixed pattern at reset.

The shared data bus appears at the ports as a separate input, output and drive-enable.

Top module: `srch_rd_top`

## Requirements
- R1: An instruction is accepted only in a cycle where `cmd_valid`=1, `cmd[1:0]`=2'b00 (read opcode) and no transaction is in progress. Any other opcode produces no acknowledge.
- R2: The device is selected when `dq_in[25:21]` equals `dev_id`, or when `dq_in[25:21]`=5'b11111 and `last_dev`=1. A read that is not selected produces no acknowledge, no bus drive and no SRAM strobe.
- R3: With `cmd[2]`=0 (single read), `ack` is high only in cycle 5, counting the instruction cycle as cycle 1. A new instruction is accepted from cycle 7 onward.
- R4: With `cmd[2]`=1 (burst read), BURST_LEN words are returned. Word w (from 0) is acknowledged in cycle 5+2w, and a new instruction is accepted from cycle 7+2(BURST_LEN-1).
- R5: A burst takes its addresses from an internal pointer and ignores the data-bus address. The pointer resets to BURST_START, advances by one after every burst word, wraps modulo DEPTH, and keeps its value between bursts.
- R6: `dq_in[20:19]` selects the target: 00 data array, 01 mask array, 10 external SRAM, 11 device register. The single-read address is `dq_in[AW-1:0]`, and a register read uses only its low log2(REG_DEPTH) bits.
- R7: The word at address a of a bank with key k holds, in nibble n (bits 4n+3..4n), the value (a+n+k) mod 16. The keys are 0 for the data array, 9 for the mask array and 3 for the registers.
- R8: For an SRAM read, `sram_en` is high in cycles 2 to 6 and `sram_addr` = {`cmd[8:7]` of cycle 1, address}. `ack` rises in cycle 5, and `dq_oe` stays 0.
- R9: A burst aimed at the SRAM or the registers is ignored. It gives no acknowledge and no SRAM strobe, and it leaves the burst pointer unchanged.
- R10: `dq_oe` is high only in acknowledge cycles of array and register reads. `dq_out` is 0 whenever `dq_oe` is 0. After reset, `ack`, `dq_oe` and `sram_en` are 0.
- R11: An instruction presented while a transaction is running is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_id | input | 5 | This device's ID strap |
| last_dev | input | 1 | High on the last device of the cascade |
| cmd_valid | input | 1 | Command bus valid |
| cmd | input | 9 | Command bus: [1:0] opcode, [2] burst, [8:7] SRAM upper address |
| dq_in | input | DW | Data bus as seen by the device |
| dq_out | output | DW | Read data driven onto the data bus |
| dq_oe | output | 1 | Data bus drive enable |
| ack | output | 1 | Read acknowledge, one cycle per word |
| sram_en | output | 1 | External SRAM access strobe |
| sram_addr | output | AW+2 | External SRAM address, upper two bits from the command |

## Verification
Every result is tied to the cycle of its instruction. An array or register word is due 4 cycles after the instruction cycle. Burst word w is due 4+2w cycles after it. The SRAM strobe is due from 1 to 5 cycles after it. The driver stamps each expected word with its due cycle, and the monitor checks the stamp against a free-running cycle counter whenever `ack` is high, so an early, late, extra or missing acknowledge is reported. Windows in which nothing should happen, after ignored, unselected or illegal reads, are watched on `ack`, `dq_oe` and `sram_en` through the full six cycles. Later bursts then show, through the addresses they return, that the pointer was left alone.

// File: rtl/srch_rd_pkg.sv
package srch_rd_pkg;

  typedef enum logic [1:0] {
    TGT_DATA = 2'b00,
    TGT_MASK = 2'b01,
    TGT_SRAM = 2'b10,
    TGT_REG  = 2'b11
  } tgt_e;

  localparam logic [1:0] OP_READ  = 2'b00;
  localparam logic [4:0] ID_LAST  = 5'h1F;
  localparam int         ID_LO    = 21;
  localparam int         TGT_LO   = 19;

  localparam logic [3:0] KEY_DATA = 4'h0;
  localparam logic [3:0] KEY_MASK = 4'h9;
  localparam logic [3:0] KEY_REG  = 4'h3;

  // nibble n of the reset word at address a in a bank with key k
  function automatic logic [3:0] cell_nibble(int unsigned a, int unsigned n, logic [3:0] key);
    logic [31:0] s;
    s = a + n + 32'(key);
    return s[3:0];
  endfunction

  // phase (cycles since capture edge) at which word w is launched
  function automatic int unsigned beat_phase(int unsigned w);
    return 3 + 2 * w;
  endfunction

  // phase at which a transaction of nw words releases the sequencer
  function automatic int unsigned end_phase(int unsigned nw);
    return 2 * nw + 3;
  endfunction

endpackage

// File: rtl/srch_rd_array.sv
module srch_rd_array #(
  parameter int         DW    = 68,
  parameter int         DEPTH = 16,
  parameter logic [3:0] KEY   = 4'h0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic [DW-1:0]            rd_data
);
  import srch_rd_pkg::*;

  function automatic logic [DW-1:0] fill(int unsigned a);
    logic [DW-1:0] w;
    w = '0;
    for (int b = 0; b < DW; b++) begin
      logic [3:0] nb;
      nb   = cell_nibble(a, b / 4, KEY);
      w[b] = nb[2'(b % 4)];
    end
    return w;
  endfunction

  logic [DW-1:0] mem [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem[e] <= fill(e);
      else        mem[e] <= mem[e];
    end
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/srch_rd_decode.sv
module srch_rd_decode #(
  parameter int DW = 68,
  parameter int AW = 4
) (
  input  logic                     cmd_valid,
  input  logic [8:0]               cmd,
  input  logic [DW-1:0]            dq_in,
  input  logic [4:0]               dev_id,
  input  logic                     last_dev,
  output logic                     hit,
  output logic                     burst,
  output srch_rd_pkg::tgt_e        tgt,
  output logic [AW-1:0]            addr,
  output logic [1:0]               sram_hi
);
  import srch_rd_pkg::*;

  logic       is_read;
  logic       id_match;
  logic       wild_match;
  logic       selected;
  logic       legal;
  logic [4:0] id_field;

  assign id_field   = dq_in[ID_LO +: 5];
  assign is_read    = cmd_valid && (cmd[1:0] == OP_READ);
  assign id_match   = (id_field == dev_id);
  assign wild_match = (id_field == ID_LAST) && last_dev;
  assign selected   = id_match || wild_match;

  assign burst   = cmd[2];
  assign tgt     = tgt_e'(dq_in[TGT_LO +: 2]);
  assign addr    = dq_in[AW-1:0];
  assign sram_hi = cmd[8:7];

  // burst only reaches the two arrays
  assign legal = !burst || (tgt == TGT_DATA) || (tgt == TGT_MASK);
  assign hit   = is_read && selected && legal;

  logic unused_bits;
  assign unused_bits = ^{dq_in[DW-1:ID_LO+5], dq_in[TGT_LO-1:AW], cmd[6:3]};

endmodule

// File: rtl/srch_rd_seq.sv
module srch_rd_seq #(
  parameter int DW          = 68,
  parameter int DEPTH       = 16,
  parameter int BURST_LEN   = 4,
  parameter int BURST_START = 14
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     hit,
  input  logic                     burst_in,
  input  srch_rd_pkg::tgt_e        tgt_in,
  input  logic [$clog2(DEPTH)-1:0] addr_in,
  input  logic [1:0]               hi_in,
  input  logic [DW-1:0]            rd_word,
  output logic [$clog2(DEPTH)-1:0] rd_addr,
  output srch_rd_pkg::tgt_e        cap_tgt,
  output logic                     ack,
  output logic                     dq_oe,
  output logic [DW-1:0]            dq_out,
  output logic                     sram_en,
  output logic [$clog2(DEPTH)+1:0] sram_addr,
  output logic                     busy,
  output logic                     cap_evt,
  output logic                     beat_evt,
  output logic                     done_evt,
  output logic                     cap_burst,
  output logic [$clog2(DEPTH)-1:0] bptr
);
  import srch_rd_pkg::*;

  localparam int AW     = $clog2(DEPTH);
  localparam int PH_MAX = 2 * BURST_LEN + 3;
  localparam int PH_W   = $clog2(PH_MAX + 1);
  localparam int WC_W   = $clog2(BURST_LEN + 1);

  function automatic logic [AW-1:0] next_ptr(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic            busy_q;
  logic [PH_W-1:0] phase_q;
  logic [WC_W-1:0] words_q;
  logic [WC_W-1:0] nwords_q;
  tgt_e            tgt_q;
  logic            burst_q;
  logic [AW-1:0]   addr_q;
  logic [AW-1:0]   bptr_q;
  logic [1:0]      hi_q;
  logic            ack_q;
  logic [DW-1:0]   data_q;

  assign cap_evt  = !busy_q && hit;
  assign beat_evt = busy_q && (words_q < nwords_q) &&
                    (32'(phase_q) == beat_phase(32'(words_q)));
  assign done_evt = busy_q && (32'(phase_q) == end_phase(32'(nwords_q)));

  assign rd_addr = burst_q ? bptr_q : addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      phase_q  <= '0;
      words_q  <= '0;
      nwords_q <= '0;
      tgt_q    <= TGT_DATA;
      burst_q  <= 1'b0;
      addr_q   <= '0;
      bptr_q   <= AW'(BURST_START);
      hi_q     <= '0;
      ack_q    <= 1'b0;
      data_q   <= '0;
    end else begin
      ack_q <= beat_evt;
      if (beat_evt) begin
        data_q  <= (tgt_q == TGT_SRAM) ? '0 : rd_word;
        words_q <= words_q + 1'b1;
        if (burst_q) bptr_q <= next_ptr(bptr_q);
      end
      if (cap_evt) begin
        busy_q   <= 1'b1;
        phase_q  <= PH_W'(1);
        words_q  <= '0;
        nwords_q <= burst_in ? WC_W'(BURST_LEN) : WC_W'(1);
        tgt_q    <= tgt_in;
        burst_q  <= burst_in;
        addr_q   <= addr_in;
        hi_q     <= hi_in;
      end else if (done_evt) begin
        busy_q  <= 1'b0;
        phase_q <= '0;
      end else if (busy_q) begin
        phase_q <= phase_q + 1'b1;
      end
    end
  end

  assign cap_tgt   = tgt_q;
  assign ack       = ack_q;
  assign dq_oe     = ack_q && (tgt_q != TGT_SRAM);
  assign dq_out    = dq_oe ? data_q : '0;
  assign sram_en   = busy_q && (tgt_q == TGT_SRAM);
  assign sram_addr = sram_en ? {hi_q, addr_q} : '0;
  assign busy      = busy_q;
  assign cap_burst = burst_q;
  assign bptr      = bptr_q;

endmodule

// File: rtl/srch_rd_top.sv
module srch_rd_top #(
  parameter int DW          = 68,
  parameter int DEPTH       = 16,
  parameter int REG_DEPTH   = 8,
  parameter int BURST_LEN   = 4,
  parameter int BURST_START = 14
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [4:0]               dev_id,
  input  logic                     last_dev,
  input  logic                     cmd_valid,
  input  logic [8:0]               cmd,
  input  logic [DW-1:0]            dq_in,
  output logic [DW-1:0]            dq_out,
  output logic                     dq_oe,
  output logic                     ack,
  output logic                     sram_en,
  output logic [$clog2(DEPTH)+1:0] sram_addr
);
  import srch_rd_pkg::*;

  localparam int AW  = $clog2(DEPTH);
  localparam int RAW = $clog2(REG_DEPTH);
  localparam logic [3:0] BANK_KEY [2] = '{KEY_DATA, KEY_MASK};

  logic          dec_hit;
  logic          dec_burst;
  tgt_e          dec_tgt;
  logic [AW-1:0] dec_addr;
  logic [1:0]    dec_hi;

  logic [AW-1:0] rd_addr;
  tgt_e          cap_tgt;
  logic [DW-1:0] bank_data [3];
  logic [DW-1:0] rd_word;

  logic          busy_w;
  logic          cap_evt_w;
  logic          beat_evt_w;
  logic          done_evt_w;
  logic          burst_w;
  logic [AW-1:0] bptr_w;

  srch_rd_decode #(.DW(DW), .AW(AW)) i_dec (
    .cmd_valid (cmd_valid),
    .cmd       (cmd),
    .dq_in     (dq_in),
    .dev_id    (dev_id),
    .last_dev  (last_dev),
    .hit       (dec_hit),
    .burst     (dec_burst),
    .tgt       (dec_tgt),
    .addr      (dec_addr),
    .sram_hi   (dec_hi)
  );

  for (genvar g = 0; g < 2; g++) begin : g_bank
    srch_rd_array #(.DW(DW), .DEPTH(DEPTH), .KEY(BANK_KEY[g])) i_arr (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_addr (rd_addr),
      .rd_data (bank_data[g])
    );
  end

  srch_rd_array #(.DW(DW), .DEPTH(REG_DEPTH), .KEY(KEY_REG)) i_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_addr (rd_addr[RAW-1:0]),
    .rd_data (bank_data[2])
  );

  always_comb begin
    case (cap_tgt)
      TGT_DATA: rd_word = bank_data[0];
      TGT_MASK: rd_word = bank_data[1];
      TGT_REG:  rd_word = bank_data[2];
      default:  rd_word = '0;
    endcase
  end

  srch_rd_seq #(
    .DW(DW), .DEPTH(DEPTH), .BURST_LEN(BURST_LEN), .BURST_START(BURST_START)
  ) i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit       (dec_hit),
    .burst_in  (dec_burst),
    .tgt_in    (dec_tgt),
    .addr_in   (dec_addr),
    .hi_in     (dec_hi),
    .rd_word   (rd_word),
    .rd_addr   (rd_addr),
    .cap_tgt   (cap_tgt),
    .ack       (ack),
    .dq_oe     (dq_oe),
    .dq_out    (dq_out),
    .sram_en   (sram_en),
    .sram_addr (sram_addr),
    .busy      (busy_w),
    .cap_evt   (cap_evt_w),
    .beat_evt  (beat_evt_w),
    .done_evt  (done_evt_w),
    .cap_burst (burst_w),
    .bptr      (bptr_w)
  );

endmodule

// File: rtl/srch_rd_chk.sv
module srch_rd_chk #(
  parameter int AW    = 4,
  parameter int DEPTH = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ack,
  input logic          dq_oe,
  input logic          sram_en,
  input logic          busy,
  input logic          cap_evt,
  input logic          beat_evt,
  input logic          done_evt,
  input logic          burst,
  input logic [AW-1:0] bptr
);

  a_r3_ack_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  a_r3_no_ack_after_cap: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> !ack);

  a_r10_oe_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> ack);

  a_r8_sram_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    sram_en |-> !dq_oe);

  a_r11_ack_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> busy);

  a_r4_no_beat_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |-> !beat_evt);

  a_r5_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_evt && burst) |=>
      (bptr == (($past(bptr) == AW'(DEPTH - 1)) ? '0 : $past(bptr) + 1'b1)));

  a_r9_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(beat_evt && burst) |=> $stable(bptr));

endmodule

bind srch_rd_top srch_rd_chk #(.AW(AW), .DEPTH(DEPTH)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ack      (ack),
  .dq_oe    (dq_oe),
  .sram_en  (sram_en),
  .busy     (busy_w),
  .cap_evt  (cap_evt_w),
  .beat_evt (beat_evt_w),
  .done_evt (done_evt_w),
  .burst    (burst_w),
  .bptr     (bptr_w)
);

// File: tb/test_srch_rd_top.sv
`timescale 1ns/1ps
module test_srch_rd_top;

  localparam int DW = 68;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [4:0]    dev_id = 5'd6;
  logic          last_dev = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [8:0]    cmd = '0;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out;
  logic          dq_oe;
  logic          ack;
  logic          sram_en;
  logic [5:0]    sram_addr;

  srch_rd_top i_srch_rd_top (
    .clk(clk), .rst_n(rst_n), .dev_id(dev_id), .last_dev(last_dev),
    .cmd_valid(cmd_valid), .cmd(cmd), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .ack(ack),
    .sram_en(sram_en), .sram_addr(sram_addr)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int            at;
    logic [DW-1:0] data;
    logic          oe;
    string         tag;
  } exp_t;

  exp_t exp_q[$];
  int   total = 0;
  int   bad = 0;
  bit   run = 1'b0;
  bit   ended = 1'b0;
  int   bptr_m = 14;

  function automatic logic [DW-1:0] model_word(int a, int key);
    logic [DW-1:0] w;
    w = '0;
    for (int n = 16; n >= 0; n--) w = {w[DW-5:0], 4'((a + n + key) % 16)};
    return w;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [DW-1:0] got, input logic [DW-1:0] want);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, want);
    end
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && run) begin
      if (dq_oe && !ack) check(1'b0, "R10", "drive without ack", 68'(dq_oe), 68'(0));
      if (!dq_oe && dq_out != '0) check(1'b0, "R10", "dq_out idle", dq_out, '0);
      if (ack) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3", "unexpected ack cycle", 68'(cyc), 68'(0));
        end else begin
          exp_t it;
          it = exp_q.pop_front();
          check(cyc == it.at, it.tag, "ack cycle", 68'(cyc), 68'(it.at));
          check(dq_out == it.data, it.tag, "data", dq_out, it.data);
          check(dq_oe == it.oe, it.tag, "dq_oe", 68'(dq_oe), 68'(it.oe));
        end
      end
    end
  end

  // key for each target: data 0, mask 9, reg 3; reg index low 3 bits
  function automatic int tkey(logic [1:0] tgt);
    return (tgt == 2'b01) ? 9 : (tgt == 2'b11) ? 3 : 0;
  endfunction

  // drive one instruction and push what it should produce
  task automatic do_read(input logic [4:0] id, input logic bst, input logic [1:0] tgt,
                         input logic [3:0] adr, input logic [1:0] hi, input logic [1:0] op,
                         input bit expect_hit, input string tag);
    int  t0;
    int  n;
    int  span;
    bit  quiet;
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd = {hi, 4'b0000, bst, op};
    dq_in = '0;
    dq_in[25:21] = id;
    dq_in[20:19] = tgt;
    dq_in[3:0] = adr;
    t0 = cyc;
    n = bst ? 4 : 1;
    if (expect_hit) begin
      for (int w = 0; w < n; w++) begin
        exp_t it;
        int a;
        if (bst) begin
          a = bptr_m;
          bptr_m = (bptr_m + 1) % 16;
        end else begin
          a = (tgt == 2'b11) ? int'(adr) % 8 : int'(adr);
        end
        it.at = t0 + 4 + 2 * w;
        it.data = (tgt == 2'b10) ? '0 : model_word(a, tkey(tgt));
        it.oe = (tgt != 2'b10);
        it.tag = tag;
        exp_q.push_back(it);
      end
      span = 6 + 2 * (n - 1);
    end else begin
      span = 6;
    end
    quiet = 1'b1;
    for (int k = 1; k < span; k++) begin
      @(negedge clk);
      if (k == 1) begin
        cmd_valid = 1'b0;
        cmd = '0;
        dq_in = '0;
      end
      if (!expect_hit && (ack || dq_oe || sram_en)) quiet = 1'b0;
      if (expect_hit && tgt == 2'b10) begin
        check(sram_en == 1'b1, "R8", "sram_en", 68'(sram_en), 68'(1));
        check(sram_addr == {hi, adr}, "R8", "sram_addr", 68'(sram_addr), 68'({hi, adr}));
      end else if (expect_hit) begin
        if (sram_en) check(1'b0, "R8", "sram_en on array read", 68'(1), 68'(0));
      end
    end
    if (!expect_hit) check(quiet, tag, "ignored read stayed silent", 68'(!quiet), 68'(0));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "WATCHDOG", "timeout", 68'(cyc), 68'(0));
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(ack == 1'b0, "R10", "reset ack", 68'(ack), 68'(0));
    check(dq_oe == 1'b0, "R10", "reset dq_oe", 68'(dq_oe), 68'(0));
    check(sram_en == 1'b0, "R10", "reset sram_en", 68'(sram_en), 68'(0));
    check(dq_out == '0, "R10", "reset dq_out", dq_out, '0);
    run = 1'b1;

    do_read(5'd6, 1'b0, 2'b00, 4'd5, 2'b00, 2'b00, 1'b1, "R3 R7 single data");
    do_read(5'd6, 1'b0, 2'b01, 4'd12, 2'b00, 2'b00, 1'b1, "R6 R7 single mask");
    do_read(5'd6, 1'b0, 2'b11, 4'd3, 2'b00, 2'b00, 1'b1, "R6 register");
    do_read(5'd6, 1'b0, 2'b11, 4'd13, 2'b00, 2'b00, 1'b1, "R6 register index wrap");
    do_read(5'd6, 1'b0, 2'b10, 4'd7, 2'b10, 2'b00, 1'b1, "R8 sram read");
    do_read(5'd7, 1'b0, 2'b00, 4'd5, 2'b00, 2'b00, 1'b0, "R2 other id");
    do_read(5'd31, 1'b0, 2'b00, 4'd1, 2'b00, 2'b00, 1'b0, "R2 wildcard not last");
    last_dev = 1'b1;
    do_read(5'd31, 1'b0, 2'b00, 4'd1, 2'b00, 2'b00, 1'b1, "R2 wildcard last");
    do_read(5'd6, 1'b0, 2'b00, 4'd1, 2'b00, 2'b01, 1'b0, "R1 other opcode");
    do_read(5'd6, 1'b1, 2'b00, 4'd9, 2'b00, 2'b00, 1'b1, "R4 R5 burst data wrap");
    do_read(5'd6, 1'b1, 2'b10, 4'd2, 2'b01, 2'b00, 1'b0, "R9 burst sram");
    do_read(5'd6, 1'b1, 2'b11, 4'd2, 2'b00, 2'b00, 1'b0, "R9 burst register");
    do_read(5'd6, 1'b1, 2'b01, 4'd0, 2'b00, 2'b00, 1'b1, "R5 R9 burst mask continues");

    // R11: second instruction in cycle 3 must be ignored
    begin
      exp_t it;
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd = 9'b0;
      dq_in = '0;
      dq_in[25:21] = 5'd6;
      dq_in[3:0] = 4'd2;
      it.at = cyc + 4;
      it.data = model_word(2, 0);
      it.oe = 1'b1;
      it.tag = "R11 busy ignore";
      exp_q.push_back(it);
      @(negedge clk);
      cmd_valid = 1'b0;
      @(negedge clk);
      cmd_valid = 1'b1;
      dq_in[3:0] = 4'd9;
      @(negedge clk);
      cmd_valid = 1'b0;
      dq_in = '0;
      repeat (8) @(negedge clk);
    end

    check(exp_q.size() == 0, "R3", "missing acks", 68'(exp_q.size()), 68'(0));
    finish_up();
  end

endmodule